// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block turns one register write into a complete transaction on an 8-bit asynchronous NAND flash bus. Software first loads the second-opcode word, the byte count and the two address words. It then writes the first-opcode word with its start bit set. The sequencer then runs the phases in a fixed order without further help:

- the first opcode, as a command cycle;
- a programmable number of address cycles;
- an optional read or write data phase against a local byte buffer;
- an optional second opcode, such as a program confirm or a read start;
- a wait, first for a fixed settling interval and then for the flash to report ready.

Completion is reported through a write-one-to-clear status register. That register also drives an interrupt line.

Every bus cycle has the same three parts, and each part lasts a fixed number of clocks set by a parameter. First the data and the latch signals settle with the strobe high (setup). Then the write or read strobe is held low (pulse). Then the strobe goes high again while the other signals stay stable (hold). All bus outputs are registered. The local buffer sits outside the block. The block presents a byte index to it, reads write data from it combinationally, and writes read data into it through a one-cycle enable.

Top module: `nand_cmd_seq`

Register map (word index on `regAddr`):

| Index | Register |
|---|---|
| 0 | Control word. Holds the first opcode and starts a transaction. |
| 1 | Second-opcode word |
| 2 | Byte count |
| 3 | Address word A |
| 4 | Address word B |
| 5 | Interrupt status |
| 6 | Status. Bit 0 is busy. |

## Requirements
- R1: Writing register 0 with bit 31 set while idle starts a transaction. The status register (index 6) then reads bit 0 = 1 until the transaction ends. CE_n stays low for the whole transaction. The first bus cycle carries register 0 bits 7:0 with CLE high and ALE low. When idle, CE_n, WE_n and RE_n are high and CLE and ALE are low.
- R2: Each bus cycle holds its strobe (WE_n or RE_n) low for exactly PULSE clocks, and WE_n and RE_n are never low together.
- R3: Register 0 bit 30 enables the address phase. Bits 29:27 hold the number of address cycles minus one, so 1 to 8 cycles are possible. With bit 30 clear, no address cycle is sent.
- R4: Address cycles have ALE high and CLE low. Address cycle i carries byte i of the 64-bit value {16'h0, wordB[31:0], wordA[15:0]}, least-significant byte first.
- R5: Register 0 bit 26 selects a read data phase of N bytes, where N is register 2. Each byte is latched from the IO bus as RE_n rises and is written to the buffer at index k, for k = 0 to N-1. If bits 26 and 25 are both set, the phase is a read.
- R6: Register 0 bit 25, with bit 26 clear, selects a write data phase. It sends N cycles with CLE and ALE low, and cycle k carries the buffer byte at index k.
- R7: There is no data phase when bits 26 and 25 are both clear, or when N is 0. In that case no data bus cycle occurs and no buffer write takes place.
- R8: Register 1 bit 8 enables a second command cycle, carrying register 1 bits 7:0 with CLE high. It comes after all address and data cycles.
- R9: After the last bus cycle, the sequencer waits at least TWB_CYC clocks. It then waits for R/B_n to be high before it sets status bit 31 (command done).
- R10: Status bit 28 (transfer done) is set at the end of a data phase. It stays clear for transactions that have no data phase.
- R11: Writing a 1 to status bit 31 or bit 28 clears that bit and leaves the other unchanged. The interrupt output is the OR of the two bits.
- R12: A write to register 0 while busy is ignored: the register keeps its value and no new transaction starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register word index |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regAddr (combinational) |
| irq | output | 1 | OR of the two status bits |
| ceN | output | 1 | Flash chip enable, active low |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| weN | output | 1 | Write strobe, active low |
| reN | output | 1 | Read strobe, active low |
| ioOut | output | 8 | Byte driven onto the flash IO bus |
| ioOe | output | 1 | Output enable for ioOut |
| ioIn | input | 8 | Byte read from the flash IO bus |
| rbN | input | 1 | Flash ready/busy, low while busy |
| bufIdx | output | LEN_W | Buffer byte index for the data phase |
| bufRdData | input | 8 | Buffer byte at bufIdx (write phase source) |
| bufWrEn | output | 1 | Buffer write enable for a read byte |
| bufWrData | output | 8 | Byte to store at bufIdx |

## Verification
A phase-selection error shows on the flash bus within one bus cycle. It appears as a command, address or data cycle that is missing, extra or out of place, so the bench compares every WE_n cycle against a list it computes itself. A byte counter that is off by one shows up at the end of a phase, as a wrong number of address or data cycles, or in the buffer index at the first buffer write. A fault in the ready wait or in the status logic appears only after the final cycle. The done bit then rises before R/B_n is released, or sooner than the settling interval allows, so each transaction's completion time is measured against the moment R/B_n was released.

// File: rtl/nseq_pkg.sv
package nseq_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CMD1,
    S_ADDR,
    S_DATA,
    S_CMD2,
    S_TWB,
    S_WRB
  } seq_state_t;

  // Configuration decoded from the register file, seen by the control FSM.
  typedef struct packed {
    logic       startReq;
    logic       rbReady;
    logic       addrEn;
    logic [2:0] addrCntM1;
    logic       rdMode;
    logic       hasData;
    logic       cmd2En;
  } seq_cfg_t;

  // Per-cycle strobes from the control FSM to the datapath.
  typedef struct packed {
    logic       active;
    logic       selCmd1;
    logic       selCmd2;
    logic       selAddr;
    logic       selWr;
    logic       weLow;
    logic       reLow;
    logic       latchRd;
    logic       wrStep;
    logic       clrIdx;
    logic       setCmdDone;
    logic       setXferDone;
    logic [2:0] addrByte;
  } seq_strb_t;

endpackage

// File: rtl/nseq_ctrl.sv
module nseq_ctrl
  import nseq_pkg::*;
#(
  parameter int SETUP   = 1,
  parameter int PULSE   = 2,
  parameter int HOLD    = 1,
  parameter int TWB_CYC = 10,
  parameter int LEN_W   = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  seq_cfg_t         cfg,
  input  logic [LEN_W-1:0] dataLen,
  output seq_strb_t        strb,
  output logic             busy
);

  localparam int BUS_T = SETUP + PULSE + HOLD;
  localparam int TMAX  = (BUS_T > TWB_CYC) ? BUS_T : TWB_CYC;
  localparam int TCW   = $clog2(TMAX + 1);
  localparam logic [TCW-1:0] T_LAST   = TCW'(BUS_T - 1);
  localparam logic [TCW-1:0] LOW_BEG  = TCW'(SETUP);
  localparam logic [TCW-1:0] LOW_END  = TCW'(SETUP + PULSE);
  localparam logic [TCW-1:0] TWB_LAST = TCW'(TWB_CYC - 1);

  seq_state_t       state;
  logic [TCW-1:0]   tCnt;
  logic [LEN_W-1:0] byteCnt;

  logic       busCyc, lastT, inLow, addrLast, dataLast;
  seq_state_t afterCmd1, afterAddr, afterData;

  assign busCyc   = (state == S_CMD1) || (state == S_ADDR) ||
                    (state == S_DATA) || (state == S_CMD2);
  assign lastT    = (tCnt == T_LAST);
  assign inLow    = (tCnt >= LOW_BEG) && (tCnt < LOW_END);
  assign addrLast = (byteCnt == LEN_W'(cfg.addrCntM1));
  assign dataLast = (byteCnt == dataLen - LEN_W'(1));

  // Phase order is fixed; each absent phase falls through to the next.
  assign afterData = cfg.cmd2En  ? S_CMD2 : S_TWB;
  assign afterAddr = cfg.hasData ? S_DATA : afterData;
  assign afterCmd1 = cfg.addrEn  ? S_ADDR : afterAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      tCnt    <= '0;
      byteCnt <= '0;
    end else begin
      unique case (state)
        S_IDLE: begin
          if (cfg.startReq) begin
            state   <= S_CMD1;
            tCnt    <= '0;
            byteCnt <= '0;
          end
        end
        S_CMD1, S_ADDR, S_DATA, S_CMD2: begin
          if (!lastT) begin
            tCnt <= tCnt + 1'b1;
          end else begin
            tCnt <= '0;
            case (state)
              S_CMD1: begin
                state   <= afterCmd1;
                byteCnt <= '0;
              end
              S_ADDR: begin
                if (addrLast) begin
                  state   <= afterAddr;
                  byteCnt <= '0;
                end else begin
                  byteCnt <= byteCnt + 1'b1;
                end
              end
              S_DATA: begin
                if (dataLast) begin
                  state   <= afterData;
                  byteCnt <= '0;
                end else begin
                  byteCnt <= byteCnt + 1'b1;
                end
              end
              default: state <= S_TWB;
            endcase
          end
        end
        S_TWB: begin
          if (tCnt == TWB_LAST) begin
            state <= S_WRB;
            tCnt  <= '0;
          end else begin
            tCnt <= tCnt + 1'b1;
          end
        end
        S_WRB: begin
          if (cfg.rbReady) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strb             = '0;
    strb.active      = (state != S_IDLE);
    strb.selCmd1     = (state == S_CMD1);
    strb.selCmd2     = (state == S_CMD2);
    strb.selAddr     = (state == S_ADDR);
    strb.selWr       = (state == S_DATA) && !cfg.rdMode;
    strb.weLow       = busCyc && inLow && !((state == S_DATA) && cfg.rdMode);
    strb.reLow       = (state == S_DATA) && cfg.rdMode && inLow;
    strb.latchRd     = (state == S_DATA) && cfg.rdMode && (tCnt == LOW_END);
    strb.wrStep      = (state == S_DATA) && !cfg.rdMode && lastT;
    strb.clrIdx      = (state == S_IDLE) && cfg.startReq;
    strb.setCmdDone  = (state == S_WRB) && cfg.rbReady;
    strb.setXferDone = (state == S_DATA) && lastT && dataLast;
    strb.addrByte    = byteCnt[2:0];
  end

  assign busy = strb.active;

endmodule

// File: rtl/nseq_dpath.sv
module nseq_dpath
  import nseq_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [2:0]       regAddr,
  input  logic [31:0]      regWrData,
  output logic [31:0]      regRdData,
  input  seq_strb_t        strb,
  input  logic             busy,
  output seq_cfg_t         cfg,
  output logic [LEN_W-1:0] dataLen,
  output logic [1:0]       irqStat,
  output logic             ceN,
  output logic             cle,
  output logic             ale,
  output logic             weN,
  output logic             reN,
  output logic [7:0]       ioOut,
  output logic             ioOe,
  input  logic [7:0]       ioIn,
  input  logic             rbN,
  output logic [LEN_W-1:0] bufIdx,
  input  logic [7:0]       bufRdData,
  output logic             bufWrEn,
  output logic [7:0]       bufWrData
);

  localparam logic [2:0] A_CTL1 = 3'd0;
  localparam logic [2:0] A_CTL2 = 3'd1;
  localparam logic [2:0] A_LEN  = 3'd2;
  localparam logic [2:0] A_ADR1 = 3'd3;
  localparam logic [2:0] A_ADR2 = 3'd4;
  localparam logic [2:0] A_IRQ  = 3'd5;
  localparam logic [2:0] A_STAT = 3'd6;

  logic [31:0]      ctrl1R, ctrl2R, addr1R, addr2R;
  logic [LEN_W-1:0] lenR;
  logic             doneR, xferR, rbMeta, rbSync;
  logic             wrCtl1, wrIrq;
  logic [63:0]      addrVec;
  logic [7:0]       addrByteVal;

  assign wrCtl1 = regWrEn && (regAddr == A_CTL1) && !busy;
  assign wrIrq  = regWrEn && (regAddr == A_IRQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrl1R <= '0;
      ctrl2R <= '0;
      addr1R <= '0;
      addr2R <= '0;
      lenR   <= '0;
    end else if (regWrEn) begin
      case (regAddr)
        A_CTL1:  if (!busy) ctrl1R <= regWrData;
        A_CTL2:  ctrl2R <= regWrData;
        A_LEN:   lenR   <= regWrData[LEN_W-1:0];
        A_ADR1:  addr1R <= regWrData;
        A_ADR2:  addr2R <= regWrData;
        default: ;
      endcase
    end
  end

  // Status bits: a new event wins over a same-cycle clear.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneR <= 1'b0;
      xferR <= 1'b0;
    end else begin
      doneR <= strb.setCmdDone  | (doneR & !(wrIrq & regWrData[31]));
      xferR <= strb.setXferDone | (xferR & !(wrIrq & regWrData[28]));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rbMeta <= 1'b0;
      rbSync <= 1'b0;
    end else begin
      rbMeta <= rbN;
      rbSync <= rbMeta;
    end
  end

  always_comb begin
    cfg           = '0;
    cfg.startReq  = wrCtl1 && regWrData[31];
    cfg.rbReady   = rbSync;
    cfg.addrEn    = ctrl1R[30];
    cfg.addrCntM1 = ctrl1R[29:27];
    cfg.rdMode    = ctrl1R[26];
    cfg.hasData   = (ctrl1R[26] || ctrl1R[25]) && (lenR != '0);
    cfg.cmd2En    = ctrl2R[8];
  end

  assign dataLen     = lenR;
  assign irqStat     = {doneR, xferR};
  assign addrVec     = {16'h0000, addr2R, addr1R[15:0]};
  assign addrByteVal = addrVec[{strb.addrByte, 3'b000} +: 8];

  // Registered flash bus outputs.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ceN   <= 1'b1;
      cle   <= 1'b0;
      ale   <= 1'b0;
      weN   <= 1'b1;
      reN   <= 1'b1;
      ioOe  <= 1'b0;
      ioOut <= '0;
    end else begin
      ceN  <= !strb.active;
      cle  <= strb.selCmd1 || strb.selCmd2;
      ale  <= strb.selAddr;
      weN  <= !strb.weLow;
      reN  <= !strb.reLow;
      ioOe <= strb.selCmd1 || strb.selCmd2 || strb.selAddr || strb.selWr;
      if (strb.selCmd1)      ioOut <= ctrl1R[7:0];
      else if (strb.selCmd2) ioOut <= ctrl2R[7:0];
      else if (strb.selAddr) ioOut <= addrByteVal;
      else if (strb.selWr)   ioOut <= bufRdData;
      else                   ioOut <= '0;
    end
  end

  // Buffer side: read bytes are captured as RE_n rises; the index steps
  // after each write byte, or in the cycle after a read byte is stored.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufWrEn   <= 1'b0;
      bufWrData <= '0;
      bufIdx    <= '0;
    end else begin
      bufWrEn <= strb.latchRd;
      if (strb.latchRd) bufWrData <= ioIn;
      if (strb.clrIdx)                     bufIdx <= '0;
      else if (strb.wrStep || bufWrEn)     bufIdx <= bufIdx + 1'b1;
    end
  end

  always_comb begin
    case (regAddr)
      A_CTL1:  regRdData = ctrl1R;
      A_CTL2:  regRdData = ctrl2R;
      A_LEN:   regRdData = 32'(lenR);
      A_ADR1:  regRdData = addr1R;
      A_ADR2:  regRdData = addr2R;
      A_IRQ:   regRdData = {doneR, 2'b00, xferR, 28'h0};
      A_STAT:  regRdData = {31'h0, busy};
      default: regRdData = '0;
    endcase
  end

endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
  import nseq_pkg::*;
#(
  parameter int SETUP   = 1,
  parameter int PULSE   = 2,
  parameter int HOLD    = 1,
  parameter int TWB_CYC = 10,
  parameter int LEN_W   = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [2:0]       regAddr,
  input  logic [31:0]      regWrData,
  output logic [31:0]      regRdData,
  output logic             irq,
  output logic             ceN,
  output logic             cle,
  output logic             ale,
  output logic             weN,
  output logic             reN,
  output logic [7:0]       ioOut,
  output logic             ioOe,
  input  logic [7:0]       ioIn,
  input  logic             rbN,
  output logic [LEN_W-1:0] bufIdx,
  input  logic [7:0]       bufRdData,
  output logic             bufWrEn,
  output logic [7:0]       bufWrData
);

  seq_cfg_t         cfg;
  seq_strb_t        strb;
  logic             busy;
  logic [LEN_W-1:0] dataLen;
  logic [1:0]       irqStat;

  nseq_ctrl #(
    .SETUP(SETUP), .PULSE(PULSE), .HOLD(HOLD),
    .TWB_CYC(TWB_CYC), .LEN_W(LEN_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cfg(cfg), .dataLen(dataLen),
    .strb(strb), .busy(busy)
  );

  nseq_dpath #(.LEN_W(LEN_W)) u_dp (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData),
    .strb(strb), .busy(busy), .cfg(cfg), .dataLen(dataLen),
    .irqStat(irqStat),
    .ceN(ceN), .cle(cle), .ale(ale), .weN(weN), .reN(reN),
    .ioOut(ioOut), .ioOe(ioOe), .ioIn(ioIn), .rbN(rbN),
    .bufIdx(bufIdx), .bufRdData(bufRdData),
    .bufWrEn(bufWrEn), .bufWrData(bufWrData)
  );

  assign irq = |irqStat;

endmodule

// File: rtl/nand_cmd_seq_chk.sv
module nand_cmd_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       ceN,
  input logic       cle,
  input logic       ale,
  input logic       weN,
  input logic       reN,
  input logic       rbN,
  input logic       busy,
  input logic       cmdDone,
  input logic       startTry,
  input logic [7:0] opcode
);

  // R2: the two strobes are never low together
  a_r2_strobe_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(!weN && !reN));

  // R4: command and address latches never both high
  a_r4_latch_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(cle && ale));

  // R1: an idle sequencer leaves the bus deselected and quiet
  a_r1_idle_bus: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && $past(!busy)) |-> (ceN && weN && reN && !cle && !ale));

  // R9: done rises only after ready has been seen through the synchroniser
  a_r9_done_after_ready: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cmdDone) |-> $past(rbN, 3));

  // R12: a start attempt during a transaction leaves the opcode untouched
  a_r12_ignore_busy: assert property (@(posedge clk) disable iff (!rstN)
    (startTry && busy) |=> $stable(opcode));

endmodule

bind nand_cmd_seq nand_cmd_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .ceN(ceN), .cle(cle), .ale(ale),
  .weN(weN), .reN(reN), .rbN(rbN), .busy(busy),
  .cmdDone(irqStat[1]),
  .startTry(regWrEn && (regAddr == 3'd0) && regWrData[31]),
  .opcode(u_dp.ctrl1R[7:0])
);

// File: tb/nand_cmd_seq_test.sv
module nand_cmd_seq_test;

  localparam int SETUP = 1, PULSE = 2, HOLD = 1, TWB = 10, LW = 12;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rstN, regWrEn, rbN, irq, ceN, cle, ale, weN, reN, ioOe, bufWrEn;
  logic [2:0]    regAddr;
  logic [31:0]   regWrData, regRdData;
  logic [7:0]    ioOut, ioIn, bufRdData, bufWrData;
  logic [LW-1:0] bufIdx;

  int nChk = 0, nErr = 0;
  bit finished = 0;

  function automatic logic [7:0] wrPat(int k); return 8'((k * 7 + 49) & 255); endfunction
  function automatic logic [7:0] rdPat(int k); return 8'((k * 13 + 5) & 255); endfunction

  assign bufRdData = wrPat(int'(bufIdx));

  nand_cmd_seq #(.SETUP(SETUP), .PULSE(PULSE), .HOLD(HOLD), .TWB_CYC(TWB), .LEN_W(LW)) uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .irq(irq), .ceN(ceN), .cle(cle), .ale(ale), .weN(weN), .reN(reN),
    .ioOut(ioOut), .ioOe(ioOe), .ioIn(ioIn), .rbN(rbN), .bufIdx(bufIdx),
    .bufRdData(bufRdData), .bufWrEn(bufWrEn), .bufWrData(bufWrData));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Flash model and bus log, all on the falling edge.
  logic [9:0] busLog [64];
  logic [7:0] rdLog [32];
  int rdIdxLog [32];
  int busN, rdN, rdCount, busyLen, busyLeft, cyc, lastWeCyc, relCyc;
  int weLowCnt, reLowCnt, weMin, weMax, reMin, reMax;
  logic [9:0] pend;
  logic prevWe, prevRe;

  initial begin
    busN = 0; rdN = 0; rdCount = 0; busyLen = 0; busyLeft = 0; cyc = 0;
    lastWeCyc = 0; relCyc = 0; weLowCnt = 0; reLowCnt = 0;
    weMin = 999; weMax = 0; reMin = 999; reMax = 0;
    pend = '0; prevWe = 1'b1; prevRe = 1'b1; rbN = 1'b1; ioIn = 8'h00;
  end

  always @(negedge clk) begin
    cyc++;
    if (busyLeft > 0) begin
      busyLeft--;
      if (busyLeft == 0) begin rbN = 1'b1; relCyc = cyc; end
    end
    if (!weN) begin pend = {cle, ale, ioOut}; weLowCnt++; end
    if (weN && !prevWe) begin
      if (busN < 64) busLog[busN] = pend;
      busN++;
      lastWeCyc = cyc;
      if (weLowCnt < weMin) weMin = weLowCnt;
      if (weLowCnt > weMax) weMax = weLowCnt;
      weLowCnt = 0;
      if (pend[9] && busyLen > 0) begin rbN = 1'b0; busyLeft = busyLen; end
    end
    if (!reN) reLowCnt++;
    if (!reN && prevRe) begin ioIn = rdPat(rdCount); rdCount++; end
    if (reN && !prevRe) begin
      if (reLowCnt < reMin) reMin = reLowCnt;
      if (reLowCnt > reMax) reMax = reLowCnt;
      reLowCnt = 0;
    end
    if (bufWrEn) begin
      if (rdN < 32) begin rdLog[rdN] = bufWrData; rdIdxLog[rdN] = int'(bufIdx); end
      rdN++;
    end
    prevWe = weN;
    prevRe = reN;
  end

  task automatic wrReg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [2:0] a, output logic [31:0] d);
    regAddr = a;
    #1 d = regRdData;
  endtask

  localparam logic [31:0] ADR_A = 32'h5A5A_C3A1;
  localparam logic [31:0] ADR_B = 32'h7E6D_5C4B;

  function automatic logic [7:0] adrByte(int i);
    logic [63:0] v;
    v = {16'h0000, ADR_B, ADR_A[15:0]};
    return v[i*8 +: 8];
  endfunction

  // mode: 0 none, 1 read, 2 write, 3 both bits (read wins)
  task automatic runTxn(input logic [7:0] op1, input logic [7:0] op2, input int na,
                        input int mode, input bit c2, input int len, input int bl,
                        input bit poke);
    logic [9:0] exp [64];
    string tag [64];
    int n, aleN, doneCyc, t;
    logic [31:0] ctl, r;
    bit isRd, isWr, hasData, seen;
    isRd = (mode == 1) || (mode == 3);
    isWr = (mode == 2);
    hasData = (mode != 0) && (len > 0);
    @(negedge clk);
    busN = 0; rdN = 0; rdCount = 0; busyLen = bl;
    weMin = 999; weMax = 0; reMin = 999; reMax = 0;
    wrReg(3'd3, ADR_A);
    wrReg(3'd4, ADR_B);
    wrReg(3'd2, 32'(len));
    wrReg(3'd1, {23'h0, c2, op2});
    ctl = 32'h8000_0000 | 32'(op1);
    if (na > 0) ctl = ctl | (32'h1 << 30) | (32'(na - 1) << 27);
    if (mode == 1 || mode == 3) ctl = ctl | (32'h1 << 26);
    if (mode == 2 || mode == 3) ctl = ctl | (32'h1 << 25);
    wrReg(3'd0, ctl);
    rdReg(3'd6, r);
    chk("R1 busy after start", r, 32'h1);
    @(negedge clk);
    chk("R1 CE_n low while busy", 32'(ceN), 32'h0);
    if (poke) begin
      repeat (5) @(negedge clk);
      wrReg(3'd0, 32'h8000_00EE);
      rdReg(3'd0, r);
      chk("R12 control word kept while busy", r, ctl);
    end
    seen = 0; doneCyc = 0;
    for (int i = 0; i < 5000 && !seen; i++) begin
      @(negedge clk);
      rdReg(3'd5, r);
      if (r[31]) begin seen = 1; doneCyc = cyc; end
    end
    chk("R9 done bit set", 32'(seen), 32'h1);
    // expected bus cycles
    n = 0;
    exp[n] = {2'b10, op1}; tag[n] = "R1 first opcode"; n++;
    for (int i = 0; i < na; i++) begin exp[n] = {2'b01, adrByte(i)}; tag[n] = "R4 address byte"; n++; end
    if (isWr && len > 0)
      for (int k = 0; k < len; k++) begin exp[n] = {2'b00, wrPat(k)}; tag[n] = "R6 write byte"; n++; end
    if (c2) begin exp[n] = {2'b10, op2}; tag[n] = "R8 second opcode"; n++; end
    chk("R8 bus cycle count", 32'(busN), 32'(n));
    aleN = 0;
    for (int i = 0; i < busN && i < 64; i++) if (busLog[i][8]) aleN++;
    chk("R3 address cycle count", 32'(aleN), 32'(na));
    for (int i = 0; i < n && i < busN; i++) chk(tag[i], 32'(busLog[i]), 32'(exp[i]));
    if (busN > 0) begin
      chk("R2 WE_n low width min", 32'(weMin), 32'(PULSE));
      chk("R2 WE_n low width max", 32'(weMax), 32'(PULSE));
    end
    if (isRd && len > 0) begin
      chk("R5 read byte count", 32'(rdN), 32'(len));
      chk("R2 RE_n low width min", 32'(reMin), 32'(PULSE));
      chk("R2 RE_n low width max", 32'(reMax), 32'(PULSE));
      for (int k = 0; k < len && k < rdN; k++) begin
        chk("R5 read byte value", 32'(rdLog[k]), 32'(rdPat(k)));
        chk("R5 read byte index", 32'(rdIdxLog[k]), 32'(k));
      end
    end else begin
      chk("R7 no buffer write", 32'(rdN), 32'h0);
      chk("R7 no RE_n pulse", 32'(rdCount), 32'h0);
    end
    rdReg(3'd5, r);
    chk("R10 transfer done bit", 32'(r[28]), 32'(hasData));
    chk("R11 interrupt output", 32'(irq), 32'h1);
    if (bl > 0) begin
      t = (doneCyc > relCyc) ? 1 : 0;
      chk("R9 done only after ready", 32'(t), 32'h1);
    end else begin
      t = (doneCyc - lastWeCyc >= TWB) ? 1 : 0;
      chk("R9 settling wait before done", 32'(t), 32'h1);
    end
    if (poke) repeat (40) @(negedge clk);
    rdReg(3'd6, r);
    chk("R12 idle after transaction", r, 32'h0);
    if (poke) chk("R12 no second transaction", 32'(busN), 32'(n));
    if (hasData) begin
      wrReg(3'd5, 32'h1000_0000);
      rdReg(3'd5, r);
      chk("R11 clear transfer bit only", r, 32'h8000_0000);
    end
    wrReg(3'd5, 32'h9000_0000);
    rdReg(3'd5, r);
    chk("R11 status cleared", r, 32'h0);
    chk("R11 interrupt output low", 32'(irq), 32'h0);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", nErr, nChk);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nChk++; nErr++;
    $display("FAIL watchdog: run did not complete actual=hung expected=done");
    finish();
  end

  initial begin
    logic [31:0] r;
    rstN = 1'b0; regWrEn = 1'b0; regAddr = 3'd0; regWrData = '0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 reset CE_n", 32'(ceN), 32'h1);
    chk("R1 reset WE_n", 32'(weN), 32'h1);
    chk("R1 reset RE_n", 32'(reN), 32'h1);
    chk("R1 reset CLE/ALE", 32'({cle, ale}), 32'h0);
    chk("R1 reset IO enable", 32'(ioOe), 32'h0);
    chk("R11 reset interrupt", 32'(irq), 32'h0);
    rdReg(3'd5, r); chk("R11 reset status", r, 32'h0);
    rdReg(3'd6, r); chk("R1 reset busy", r, 32'h0);
    rdReg(3'd0, r); chk("R1 reset control word", r, 32'h0);

    for (int na = 0; na <= 8; na++)
      for (int mode = 0; mode <= 2; mode++)
        for (int c2 = 0; c2 <= 1; c2++)
          runTxn(8'(8'h10 + na * 16 + mode), 8'(8'h30 + mode), na, mode, c2[0],
                 (na % 3) + 1, (na % 2 == 1) ? 30 : 0, 1'b0);

    runTxn(8'h80, 8'h10, 5, 2, 1'b1, 0, 0, 1'b0);    // R7 write with zero length
    runTxn(8'h00, 8'h30, 5, 3, 1'b1, 4, 20, 1'b0);   // R5 both bits set, read wins
    runTxn(8'h60, 8'hD0, 3, 0, 1'b1, 0, 200, 1'b1);  // R12 start while busy
    runTxn(8'h90, 8'h00, 1, 1, 1'b0, 9, 0, 1'b0);    // R5 longer read

    finish();
  end

endmodule